// File: doc/BRIEF.md
# Formatted Integer Field Renderer

This block turns one argument value into the printable text of one formatted field. It takes a value of up to 64 bits together with a field specifier that has already been decoded. The specifier gives the significant size in bits, the numeric base, the justification, a minimum field width and three option flags: plus, zero-fill and signed. The block sends the finished text one ASCII byte at a time over a valid/ready stream. When the last byte has been taken, it pulses a done strobe.

A request is accepted on a valid/ready handshake. The block first generates the digits into a small internal character buffer, working from the least significant digit upward. Decimal digits come from an iterative shift-and-subtract divider that produces one quotient bit per cycle. The power-of-two bases and character mode produce one digit per cycle. The stream then emits, in order: the leading padding, the sign, the digits (most significant first) and the trailing padding. One request produces exactly one field.

Top module: `fmt_field_render`

## Requirements
- R1: `req_ready` is high only while the block is idle. Each accepted request yields exactly one `done` pulse, which lasts one cycle, and that pulse comes only after every byte of the field has been taken.
- R2: Argument bits at positions equal to or above `size_i` do not affect the output.
- R3: Base code 0 renders binary, 1 octal and 3 hexadecimal, with hex letters in lowercase `a`..`f`. Leading zeros are suppressed, and a zero value prints as a single `0`.
- R4: With `zero_i` set, a binary, octal or hex field is zero-filled to ceil(size/k) digits, where k is 1, 3 or 4 bits per digit. In decimal, `zero_i` has no effect.
- R5: Base code 2 renders decimal. With `signed_i` set and bit size-1 of the value set, the output is `-` followed by the two's-complement magnitude. In every other base, `signed_i` has no effect.
- R6: In decimal, `plus_i` prefixes `+` to a value that is not negative. In any other base it has no effect.
- R7: Base code 4 emits the value as raw bytes, most significant byte first. Leading zero bytes are skipped, so a zero value emits no bytes.
- R8: When the rendered length, sign included, is below `width_i`, spaces fill the difference. With `left_i`=0 the spaces come before the text; with `left_i`=1 they come after it.
- R9: A `width_i` smaller than the rendered length leaves the text whole, with no truncation.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A field request is presented |
| req_ready | output | 1 | The block is idle and will accept a request |
| arg_i | input | 64 | Argument value |
| size_i | input | 7 | Significant bits of the argument (1..64) |
| base_i | input | 3 | 0 binary, 1 octal, 2 decimal, 3 hex, 4 character |
| left_i | input | 1 | 1 left-justify, 0 right-justify |
| width_i | input | 8 | Minimum field width in characters |
| plus_i | input | 1 | Prefix `+` on a non-negative decimal |
| zero_i | input | 1 | Zero-fill non-decimal digits to the signal size |
| signed_i | input | 1 | Treat the value as two's complement (decimal only) |
| out_valid | output | 1 | `out_byte` holds a character |
| out_ready | input | 1 | The consumer takes the character |
| out_byte | output | 8 | ASCII character |
| done | output | 1 | One-cycle pulse once the field is complete |

## Verification
If the digit index or the remainder goes wrong inside the generator, the symptom is a wrong, missing or extra character in the stream of the same request. A lost divider step shows up as a wrong decimal digit. A bad padding or sign register shows up as a wrong character at the very start or end of the field. A stuck emission state shows up as a request whose done pulse never comes, or as a second field that starts with stale bytes. The scoreboard compares every byte as it is handshaken and checks each done pulse against an empty expectation queue. Randomised backpressure on `out_ready` also exercises the stalled-output hold rule.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic [2:0] {
    FB_BIN = 3'd0,
    FB_OCT = 3'd1,
    FB_DEC = 3'd2,
    FB_HEX = 3'd3,
    FB_CHR = 3'd4
  } fmt_base_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GEN, S_PRE, S_SIGN, S_DIG, S_POST, S_FIN
  } emit_st_e;

  function automatic logic [7:0] nib_ascii(input logic [3:0] d);
    return (d < 4'd10) ? (8'h30 + {4'd0, d}) : (8'h57 + {4'd0, d});
  endfunction
endpackage

// File: rtl/fmt_char_buf.sv
module fmt_char_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fmt_digit_gen.sv
module fmt_digit_gen
  import fmt_pkg::*;
#(
  parameter int ARG_W  = 64,
  parameter int SIZE_W = 7,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  fmt_base_e        base_i,
  input  logic [ARG_W-1:0] value_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic             zero_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);
  localparam int DIV_W = $clog2(ARG_W);

  logic             busy_q, div_q;
  logic [DIV_W-1:0] step_q;
  logic [ARG_W-1:0] val_q;
  logic [3:0]       rem_q;
  logic [CNT_W-1:0] idx_q, min_q;
  fmt_base_e        base_q;

  logic [SIZE_W+1:0] sz_ext;
  logic [CNT_W-1:0]  min_d;
  logic [4:0]        trial;
  logic              fits;
  logic [3:0]        rem_n;
  logic [7:0]        pdig;
  logic [ARG_W-1:0]  pshift;
  logic              finish;

  // minimum digit count: zero-fill only for power-of-two bases
  always_comb begin
    sz_ext = {2'b00, size_i};
    min_d  = CNT_W'(1);
    if (base_i == FB_CHR) min_d = '0;
    else if (zero_i) begin
      case (base_i)
        FB_BIN:  min_d = CNT_W'(sz_ext);
        FB_OCT:  min_d = CNT_W'((sz_ext + 2) / 3);
        FB_HEX:  min_d = CNT_W'((sz_ext + 3) >> 2);
        default: min_d = CNT_W'(1);
      endcase
    end
  end

  // one restoring-division step by ten
  always_comb begin
    trial = {rem_q, val_q[ARG_W-1]};
    fits  = (trial >= 5'd10);
    rem_n = fits ? 4'(trial - 5'd10) : trial[3:0];
  end

  always_comb begin
    case (base_q)
      FB_BIN:  begin pdig = nib_ascii({3'b000, val_q[0]}); pshift = val_q >> 1; end
      FB_OCT:  begin pdig = nib_ascii({1'b0, val_q[2:0]}); pshift = val_q >> 3; end
      FB_CHR:  begin pdig = val_q[7:0];                    pshift = val_q >> 8; end
      default: begin pdig = nib_ascii(val_q[3:0]);         pshift = val_q >> 4; end
    endcase
    finish = (val_q == '0) && (idx_q >= min_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; div_q <= 1'b0; step_q <= '0; val_q <= '0; rem_q <= '0;
      idx_q <= '0; min_q <= '0; base_q <= FB_BIN;
      done_o <= 1'b0; count_o <= '0; wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1; div_q <= 1'b0; val_q <= value_i;
        idx_q <= '0; min_q <= min_d; base_q <= base_i;
      end else if (busy_q) begin
        if (div_q) begin
          val_q  <= {val_q[ARG_W-2:0], fits};
          rem_q  <= rem_n;
          step_q <= step_q + 1'b1;
          if (step_q == DIV_W'(ARG_W - 1)) begin
            div_q     <= 1'b0;
            wr_en_o   <= 1'b1;
            wr_addr_o <= idx_q;
            wr_data_o <= 8'h30 + {4'd0, rem_n};
            idx_q     <= idx_q + 1'b1;
          end
        end else if (finish) begin
          busy_q  <= 1'b0;
          done_o  <= 1'b1;
          count_o <= idx_q;
        end else if (base_q == FB_DEC) begin
          div_q <= 1'b1; step_q <= '0; rem_q <= '0;
        end else begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= idx_q;
          wr_data_o <= pdig;
          val_q     <= pshift;
          idx_q     <= idx_q + 1'b1;
        end
      end
    end
  end

  p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
  p_addr_bound_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o < CNT_W'(ARG_W)));
  p_digit_ascii_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && base_q != FB_CHR) |->
      ((wr_data_o >= 8'h30 && wr_data_o <= 8'h39) || (wr_data_o >= 8'h61 && wr_data_o <= 8'h66)));
  p_min_digits_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_o >= min_q));
endmodule

// File: rtl/fmt_field_render.sv
module fmt_field_render
  import fmt_pkg::*;
#(
  parameter int ARG_W   = 64,
  parameter int WIDTH_W = 8,
  parameter int SIZE_W  = $clog2(ARG_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ARG_W-1:0]   arg_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [2:0]         base_i,
  input  logic               left_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               plus_i,
  input  logic               zero_i,
  input  logic               signed_i,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_byte,
  output logic               done
);
  localparam int CNT_W = $clog2(ARG_W + 1);
  localparam int AW    = $clog2(ARG_W);
  localparam int LEN_W = ((WIDTH_W > CNT_W) ? WIDTH_W : CNT_W) + 1;

  emit_st_e         st_q;
  fmt_base_e        base_in, base_q;
  logic [ARG_W-1:0] size_mask, top_bit, masked, mag, mag_q;
  logic             neg;
  logic [SIZE_W-1:0] size_q;
  logic             zero_q, left_q, gen_start_q;
  logic [WIDTH_W-1:0] width_q, pad_q;
  logic [7:0]       sign_q;
  logic [CNT_W-1:0] rd_q;
  logic             slot_free, accept;
  logic [LEN_W-1:0] len_w, wid_w;

  logic             gen_done, wr_en;
  logic [CNT_W-1:0] gen_count, wr_addr;
  logic [7:0]       wr_data, rd_data;

  assign base_in   = fmt_base_e'(base_i);
  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign slot_free = !out_valid || out_ready;

  always_comb begin
    for (int i = 0; i < ARG_W; i++) size_mask[i] = (i < int'(size_i));
    masked  = arg_i & size_mask;
    top_bit = size_mask & ~(size_mask >> 1);
    neg     = (base_in == FB_DEC) && signed_i && (|(masked & top_bit));
    mag     = neg ? ((~masked) + 1'b1) & size_mask : masked;
    len_w   = LEN_W'(gen_count) + LEN_W'(sign_q != 8'h00);
    wid_w   = LEN_W'(width_q);
  end

  fmt_digit_gen #(.ARG_W(ARG_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst(rst), .start_i(gen_start_q), .base_i(base_q), .value_i(mag_q),
    .size_i(size_q), .zero_i(zero_q), .done_o(gen_done), .count_o(gen_count),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fmt_char_buf #(.DEPTH(ARG_W), .AW(AW)) u_buf (
    .clk(clk), .we(wr_en), .waddr(AW'(wr_addr)), .wdata(wr_data),
    .raddr(AW'(rd_q - 1'b1)), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; base_q <= FB_BIN; mag_q <= '0; size_q <= '0; zero_q <= 1'b0;
      left_q <= 1'b0; width_q <= '0; pad_q <= '0; sign_q <= '0; rd_q <= '0;
      gen_start_q <= 1'b0; out_valid <= 1'b0; out_byte <= '0; done <= 1'b0;
    end else begin
      gen_start_q <= 1'b0;
      done        <= 1'b0;
      if (slot_free) out_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          base_q <= base_in; mag_q <= mag; size_q <= size_i; zero_q <= zero_i;
          left_q <= left_i; width_q <= width_i;
          sign_q <= neg ? 8'h2d : ((base_in == FB_DEC && plus_i) ? 8'h2b : 8'h00);
          gen_start_q <= 1'b1;
          st_q <= S_GEN;
        end
        S_GEN: if (gen_done) begin
          pad_q <= (wid_w > len_w) ? WIDTH_W'(wid_w - len_w) : '0;
          rd_q  <= gen_count;
          st_q  <= left_q ? S_SIGN : S_PRE;
        end
        S_PRE: if (slot_free) begin
          if (pad_q != '0) begin
            out_valid <= 1'b1; out_byte <= 8'h20; pad_q <= pad_q - 1'b1;
          end else st_q <= S_SIGN;
        end
        S_SIGN: if (slot_free) begin
          if (sign_q != 8'h00) begin out_valid <= 1'b1; out_byte <= sign_q; end
          st_q <= S_DIG;
        end
        S_DIG: if (slot_free) begin
          if (rd_q != '0) begin
            out_valid <= 1'b1; out_byte <= rd_data; rd_q <= rd_q - 1'b1;
          end else st_q <= left_q ? S_POST : S_FIN;
        end
        S_POST: if (slot_free) begin
          if (pad_q != '0) begin
            out_valid <= 1'b1; out_byte <= 8'h20; pad_q <= pad_q - 1'b1;
          end else st_q <= S_FIN;
        end
        S_FIN: if (slot_free) begin
          done <= 1'b1;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  p_busy_while_out_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/fmt_field_render_bench.sv
module fmt_field_render_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] arg_i = '0;
  logic [6:0]  size_i = '0;
  logic [2:0]  base_i = '0;
  logic        left_i = 1'b0;
  logic [7:0]  width_i = '0;
  logic        plus_i = 1'b0, zero_i = 1'b0, signed_i = 1'b0;
  logic        out_valid, out_ready = 1'b0, done;
  logic [7:0]  out_byte;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q [$];
  string cur_tag = "R1";
  bit done_flag = 0;
  bit prev_stall = 0;
  bit prev_done = 0;
  logic [7:0] prev_byte = '0;

  always #2 clk = ~clk;

  fmt_field_render u_fmt_field_render (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .arg_i(arg_i),
    .size_i(size_i), .base_i(base_i), .left_i(left_i), .width_i(width_i), .plus_i(plus_i),
    .zero_i(zero_i), .signed_i(signed_i), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: builds the expected byte stream from the requirements
  task automatic push_expected(input int base, input int size, input logic [63:0] arg,
                               input bit left, input int width, input bit plus,
                               input bit zero, input bit sgn);
    logic [63:0] msk, m, mg;
    string ds;
    logic [7:0] body [$];
    int k, mind, pad;
    bit neg, started;
    msk = (size >= 64) ? '1 : ((64'd1 << size) - 1);
    m = arg & msk;
    neg = 0; k = 1; ds = "";
    case (base)
      0: begin ds = $sformatf("%0b", m); k = 1; end
      1: begin ds = $sformatf("%0o", m); k = 3; end
      3: begin ds = $sformatf("%0h", m); k = 4; end
      2: begin
        neg = sgn && m[size-1];
        mg  = neg ? ((~m) + 1) & msk : m;
        ds  = $sformatf("%0d", mg);
      end
      default: ;
    endcase
    if (zero && base != 2 && base != 4) begin
      mind = (size + k - 1) / k;
      while (ds.len() < mind) ds = {"0", ds};
    end
    if (neg) body.push_back(8'h2d);
    else if (base == 2 && plus) body.push_back(8'h2b);
    if (base == 4) begin
      started = 0;
      for (int i = 7; i >= 0; i--) begin
        if (m[i*8 +: 8] != 0 || started) begin
          started = 1;
          body.push_back(m[i*8 +: 8]);
        end
      end
    end else begin
      for (int i = 0; i < ds.len(); i++) body.push_back(ds[i]);
    end
    pad = (width > body.size()) ? width - body.size() : 0;
    if (!left) for (int i = 0; i < pad; i++) exp_q.push_back(8'h20);
    foreach (body[i]) exp_q.push_back(body[i]);
    if (left) for (int i = 0; i < pad; i++) exp_q.push_back(8'h20);
  endtask

  task automatic run(input string tag, input int base, input int size, input logic [63:0] arg,
                     input bit left, input int width, input bit plus, input bit zero, input bit sgn);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    push_expected(base, size, arg, left, width, plus, zero, sgn);
    arg_i = arg; size_i = 7'(size); base_i = 3'(base); left_i = left; width_i = 8'(width);
    plus_i = plus; zero_i = zero; signed_i = sgn; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 busy after accept", {63'd0, req_ready}, 64'd0);
    while (!done_flag) @(negedge clk);
    done_flag = 0;
  endtask

  // monitor: pops expected bytes on each handshake and checks done pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check("R10 valid held", {63'd0, out_valid}, 64'd1);
        check("R10 byte held", {56'd0, out_byte}, {56'd0, prev_byte});
      end
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check({cur_tag, " extra byte"}, {56'd0, out_byte}, 64'hffff);
        else check(cur_tag, {56'd0, out_byte}, {56'd0, exp_q.pop_front()});
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
      if (done) begin
        check("R1 bytes left at done", 64'(exp_q.size()), 64'd0);
        if (prev_done) check("R1 done width", 64'd2, 64'd1);
        done_flag = 1;
      end
      prev_done = done;
    end
  end

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset ready", {63'd0, req_ready}, 64'd1);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset done", {63'd0, done}, 64'd0);
    run("R3 hex", 3, 16, 64'h00af, 0, 0, 0, 0, 0);
    run("R3 bin", 0, 8, 64'h05, 0, 0, 0, 0, 0);
    run("R3 oct", 1, 12, 64'o755, 0, 0, 0, 0, 0);
    run("R3 zero", 3, 16, 64'h0, 0, 0, 0, 0, 0);
    run("R2 mask", 3, 8, 64'hfff3, 0, 0, 0, 0, 0);
    run("R4 hex fill", 3, 16, 64'h0a, 0, 0, 0, 1, 0);
    run("R4 oct fill", 1, 7, 64'h05, 0, 0, 0, 1, 0);
    run("R4 bin fill", 0, 4, 64'h1, 0, 0, 0, 1, 0);
    run("R4 dec no fill", 2, 16, 64'd42, 0, 0, 0, 1, 0);
    run("R5 dec unsigned", 2, 8, 64'hff, 0, 0, 0, 0, 0);
    run("R5 dec signed", 2, 8, 64'hff, 0, 0, 0, 0, 1);
    run("R5 dec min64", 2, 64, 64'h8000000000000000, 0, 0, 0, 0, 1);
    run("R5 dec max64", 2, 64, '1, 0, 0, 0, 0, 0);
    run("R5 hex signed", 3, 8, 64'hff, 0, 0, 0, 0, 1);
    run("R2 R5 masked sign", 2, 4, 64'hf7, 0, 0, 0, 0, 1);
    run("R5 dec zero", 2, 8, 64'd0, 0, 0, 0, 0, 0);
    run("R6 plus", 2, 8, 64'd7, 0, 0, 1, 0, 0);
    run("R6 plus neg", 2, 8, 64'hfd, 0, 0, 1, 0, 1);
    run("R6 plus hex", 3, 8, 64'h7, 0, 0, 1, 0, 0);
    run("R7 chars", 4, 32, 64'h00004869, 0, 0, 0, 0, 0);
    run("R7 empty", 4, 32, 64'h0, 0, 0, 0, 0, 0);
    run("R7 R8 pad only", 4, 16, 64'h0, 0, 3, 0, 0, 0);
    run("R8 right", 2, 8, 64'hfb, 0, 6, 0, 0, 1);
    run("R8 left", 3, 8, 64'hab, 1, 5, 0, 0, 0);
    run("R8 left fill", 0, 3, 64'h2, 1, 6, 0, 1, 0);
    run("R9 no trunc", 2, 16, 64'd12345, 0, 2, 0, 0, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
      end
    join_any
    repeat (4) @(negedge clk);
    check("R1 queue drained", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule